// File: doc/BRIEF.md
# Output Power-up Ramp Sequencer

This block sequences the analog output stage of a stereo converter so that power-up and power-down produce no audible click. While the active-low reset is held, the block is in its power-down state: audio is off, the output buffers are released and a soft discharge path is switched on so the external coupling capacitors drain slowly. When reset is released the outputs are first held at ground for a settling interval, then a ramp code climbs in unit steps from zero to full scale, one step per sample-clock tick, steering the outputs up to the mid-supply level. Only when the ramp has finished is audio passed through.

The block also drives the mute-control output for an external mute circuit. Mute is high for the whole start-up sequence, while in reset, and whenever the clock-ratio valid flag reports a bad master-to-sample clock ratio. A bad ratio during playback mutes at once but leaves the sequence where it is, so playback resumes without a new ramp once the ratio is good again. All pins are plain control and status signals; there is no data stream and so no handshake.

Top module: `out_ramp_sequencer`

## Requirements
- R1: While `rst_n` is low (asynchronously), `dischg_en` is 1, `clamp_en` is 0, `audio_en` is 0, `mute_out` is 1 and `ramp_code` is 0, and all sequencing state returns to its start.
- R2: At the first rising clock edge with `rst_n` high the block enters the clamp phase: `clamp_en` becomes 1 and `dischg_en` becomes 0; a `smp_tick` in that same cycle is not counted.
- R3: The clamp phase counts `smp_tick` pulses (one tick per cycle in which `smp_tick` is 1); on the edge that counts the SETTLE_TICKS-th tick, `clamp_en` goes to 0 and the ramp phase begins with `ramp_code` equal to 0.
- R4: In the ramp phase `ramp_code` increases by exactly 1 on each counted tick and never changes otherwise; it reaches RAMP_TICKS (full scale) after RAMP_TICKS ticks and holds that value during playback.
- R5: `audio_en` becomes 1 on the edge at which `ramp_code` reaches RAMP_TICKS and stays 1 until reset; it is 0 in the clamp and ramp phases.
- R6: `mute_out` is 1 whenever `audio_en` is 0.
- R7: During playback `mute_out` equals the inverse of `ratio_ok` in the same cycle, without a clock edge in between, and a low `ratio_ok` does not clear `audio_en` or change `ramp_code`.
- R8: `ratio_ok` has no effect on the length of the clamp or ramp phases or on `ramp_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; low selects the power-down state |
| smp_tick | input | 1 | One-cycle pulse per sample-clock period |
| ratio_ok | input | 1 | High when the master-to-sample clock ratio is valid |
| clamp_en | output | 1 | Holds the outputs at ground |
| ramp_code | output | $clog2(RAMP_TICKS+1) | Ramp target toward the mid-supply level, 0 to RAMP_TICKS |
| audio_en | output | 1 | Passes audio to the outputs |
| dischg_en | output | 1 | Enables the soft discharge path |
| mute_out | output | 1 | Mute-control output, high for mute |

## Verification
The sequence is run with ticks every other cycle while `ratio_ok` toggles at random, which shows whether the clamp and ramp lengths count ticks rather than clock cycles and ignore the ratio flag. A second run with a tick on every cycle checks the edge between the clamp and ramp phases and the exact reset-release cycle, where an off-by-one in tick counting shows up. Resets issued in the middle of the clamp phase and the ramp phase separate a true return to the start from a resumed count, and dropping `ratio_ok` during playback tells an immediate mute apart from a registered one or from a restart of the ramp.

// File: rtl/ors_pkg.sv
package ors_pkg;
  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_CLAMP = 2'd1,
    PH_RAMP  = 2'd2,
    PH_PLAY  = 2'd3
  } phase_t;
endpackage

// File: rtl/ors_tick_counter.sv
// Counts sample ticks while enabled, saturates at LIMIT, clears when disabled.
module ors_tick_counter #(
  parameter int LIMIT = 1000,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  output logic [CW-1:0] count,
  output logic          last_tick
);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (!en)
      count <= '0;
    else if (tick && count != TOP)
      count <= count + 1'b1;
  end

  assign last_tick = en && tick && (count == LAST);
endmodule

// File: rtl/ors_phase_fsm.sv
// Phase sequencer: off -> clamp -> ramp -> play.
module ors_phase_fsm
  import ors_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   settle_done,
  input  logic   ramp_done,
  output phase_t phase
);
  phase_t phase_nx;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_OFF:   phase_nx = PH_CLAMP;
      PH_CLAMP: if (settle_done) phase_nx = PH_RAMP;
      PH_RAMP:  if (ramp_done)   phase_nx = PH_PLAY;
      PH_PLAY:  phase_nx = PH_PLAY;
      default:  phase_nx = PH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_OFF;
    else        phase <= phase_nx;
  end
endmodule

// File: rtl/ors_out_decode.sv
// Decodes the phase into the output-stage controls.
module ors_out_decode
  import ors_pkg::*;
(
  input  phase_t phase,
  input  logic   ratio_ok,
  output logic   clamp_en,
  output logic   audio_en,
  output logic   dischg_en,
  output logic   mute_out
);
  always_comb begin
    clamp_en  = (phase == PH_CLAMP);
    audio_en  = (phase == PH_PLAY);
    dischg_en = (phase == PH_OFF);
    mute_out  = !((phase == PH_PLAY) && ratio_ok);
  end
endmodule

// File: rtl/out_ramp_sequencer.sv
module out_ramp_sequencer
  import ors_pkg::*;
#(
  parameter int SETTLE_TICKS = 1000,
  parameter int RAMP_TICKS   = 10000,
  localparam int RW = $clog2(RAMP_TICKS + 1),
  localparam int SW = $clog2(SETTLE_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_tick,
  input  logic          ratio_ok,
  output logic          clamp_en,
  output logic [RW-1:0] ramp_code,
  output logic          audio_en,
  output logic          dischg_en,
  output logic          mute_out
);
  phase_t        phase;
  logic          settle_done;
  logic          ramp_done;
  logic [SW-1:0] settle_cnt;

  ors_tick_counter #(.LIMIT(SETTLE_TICKS)) u_settle (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (phase == PH_CLAMP),
    .tick      (smp_tick),
    .count     (settle_cnt),
    .last_tick (settle_done)
  );

  // The ramp counter keeps counting into playback, where it sits saturated.
  ors_tick_counter #(.LIMIT(RAMP_TICKS)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (phase == PH_RAMP || phase == PH_PLAY),
    .tick      (smp_tick),
    .count     (ramp_code),
    .last_tick (ramp_done)
  );

  ors_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .settle_done (settle_done),
    .ramp_done   (ramp_done && phase == PH_RAMP),
    .phase       (phase)
  );

  ors_out_decode u_dec (
    .phase     (phase),
    .ratio_ok  (ratio_ok),
    .clamp_en  (clamp_en),
    .audio_en  (audio_en),
    .dischg_en (dischg_en),
    .mute_out  (mute_out)
  );
endmodule

// File: rtl/out_ramp_sequencer_checker.sv
module out_ramp_sequencer_checker #(
  parameter int SETTLE_TICKS = 1000,
  parameter int RAMP_TICKS   = 10000,
  localparam int RW = $clog2(RAMP_TICKS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_tick,
  input logic          ratio_ok,
  input logic          clamp_en,
  input logic [RW-1:0] ramp_code,
  input logic          audio_en,
  input logic          dischg_en,
  input logic          mute_out
);
  // R1: the discharge path is only used with every other output inactive
  a_r1_dischg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    dischg_en |-> (!audio_en && !clamp_en && mute_out && ramp_code == '0));

  // R3: leaving the clamp hands over to a ramp that starts from zero
  a_r3_clamp_to_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clamp_en) |-> (ramp_code == '0 && !dischg_en && !audio_en));

  // R4: the ramp code only moves up in unit steps, and only on a tick
  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_code != $past(ramp_code)) |->
      (ramp_code == RW'($past(ramp_code) + 1'b1) && $past(smp_tick)));

  // R5: audio only with the ramp at full scale
  a_r5_audio_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
    audio_en |-> (ramp_code == RW'(RAMP_TICKS) && !clamp_en));

  // R6: mute whenever audio is off
  a_r6_mute_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !audio_en |-> mute_out);

  // R7: playback survives a bad ratio, muted
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    audio_en |=> audio_en);
  a_r7_mute_bad_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_ok |-> mute_out);
endmodule

bind out_ramp_sequencer out_ramp_sequencer_checker #(
  .SETTLE_TICKS(SETTLE_TICKS),
  .RAMP_TICKS  (RAMP_TICKS)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_tick  (smp_tick),
  .ratio_ok  (ratio_ok),
  .clamp_en  (clamp_en),
  .ramp_code (ramp_code),
  .audio_en  (audio_en),
  .dischg_en (dischg_en),
  .mute_out  (mute_out)
);

// File: tb/test_out_ramp_sequencer.sv
`timescale 1ns/1ps
module test_out_ramp_sequencer;
  localparam int SETTLE = 1000;
  localparam int RAMP   = 10000;
  localparam int RW     = $clog2(RAMP + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_tick = 1'b0;
  logic          ratio_ok = 1'b1;
  logic          clamp_en, audio_en, dischg_en, mute_out;
  logic [RW-1:0] ramp_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  out_ramp_sequencer #(.SETTLE_TICKS(SETTLE), .RAMP_TICKS(RAMP)) i_out_ramp_sequencer (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .ratio_ok(ratio_ok),
    .clamp_en(clamp_en), .ramp_code(ramp_code), .audio_en(audio_en),
    .dischg_en(dischg_en), .mute_out(mute_out)
  );

  // Behavioural reference: 0 power-down, 1 clamped, 2 ramping, 3 playing.
  int m_ph = 0;
  int m_settle = 0;
  int m_code = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_settle = 0; m_code = 0;
    end else begin
      case (m_ph)
        0: begin m_ph = 1; m_settle = 0; end
        1: if (smp_tick) begin
             m_settle++;
             if (m_settle == SETTLE) m_ph = 2;
           end
        2: if (smp_tick) begin
             m_code++;
             if (m_code == RAMP) m_ph = 3;
           end
        default: ;
      endcase
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    #1;
    if (!done) begin
      check("R1 dischg_en", int'(dischg_en), int'(m_ph == 0));
      check("R2/R3 clamp_en", int'(clamp_en), int'(m_ph == 1));
      check("R4/R8 ramp_code", int'(ramp_code), m_code);
      check("R5 audio_en", int'(audio_en), int'(m_ph == 3));
      check("R6/R7 mute_out", int'(mute_out), int'(!(m_ph == 3 && ratio_ok)));
    end
  end

  task automatic run(int n, int period, bit rand_ratio);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_tick = (i % period == 0);
      if (rand_ratio) ratio_ok = 1'($urandom % 2);
    end
    @(negedge clk);
    smp_tick = 1'b0;
  endtask

  task automatic settle_sample();
    @(negedge clk);
    #2;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    settle_sample();
    // R1 reset state
    check("R1 reset dischg", int'(dischg_en), 1);
    check("R1 reset mute", int'(mute_out), 1);
    check("R1 reset code", int'(ramp_code), 0);

    // R2: tick present in the release cycle must not count
    @(negedge clk);
    rst_n = 1'b1; smp_tick = 1'b1;
    settle_sample();
    smp_tick = 1'b0;
    check("R2 clamp after release", int'(clamp_en), 1);
    check("R2 discharge off", int'(dischg_en), 0);

    // R3/R4/R8: ticks every other cycle, ratio flag toggling
    run(2 * (SETTLE + RAMP) + 20, 2, 1'b1);
    ratio_ok = 1'b1;
    settle_sample();
    check("R5 playing", int'(audio_en), 1);
    check("R4 full scale", int'(ramp_code), RAMP);
    check("R7 unmuted", int'(mute_out), 0);

    // R7: drop ratio during playback
    ratio_ok = 1'b0;
    #1;
    check("R7 immediate mute", int'(mute_out), 1);
    run(30, 1, 1'b0);
    settle_sample();
    check("R7 no restart", int'(audio_en), 1);
    check("R7 code held", int'(ramp_code), RAMP);
    ratio_ok = 1'b1;
    settle_sample();
    check("R7 resumes", int'(mute_out), 0);

    // R1: reset during the ramp phase
    rst_n = 1'b0;
    settle_sample();
    rst_n = 1'b1;
    run(3000, 1, 1'b0);
    check("R4 mid ramp code", int'(ramp_code), m_code);
    rst_n = 1'b0;
    settle_sample();
    check("R1 mid-ramp reset code", int'(ramp_code), 0);
    check("R1 mid-ramp reset dischg", int'(dischg_en), 1);

    // R1: reset during the clamp phase, then back-to-back ticks
    rst_n = 1'b1;
    run(500, 1, 1'b0);
    rst_n = 1'b0;
    settle_sample();
    rst_n = 1'b1;
    run(SETTLE + RAMP + 10, 1, 1'b0);
    settle_sample();
    check("R5 second playback", int'(audio_en), 1);
    check("R4 second full scale", int'(ramp_code), RAMP);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule